// File: doc/BRIEF.md
# Tree Sum Reduction Engine

This block adds up a stream of unsigned values in two phases. A bank of lane accumulators is cleared when a job starts. Each incoming element is added into the lane that owns its slice: the first SLICE elements go to lane 0, the next SLICE to lane 1, and so on until every active lane has received its slice. The lanes are then folded in lockstep rounds. In each round, the upper half of the active lanes is added onto the lower half. When the active count is odd, lane 0 also takes the leftover top lane. The rounds continue until one lane remains, and that lane holds the total.

Because lane 0 absorbs the odd leftover in every round, any lane count from 1 to LANES works without padding to a power of two. With ten lanes, the active count goes 10, 5, 2, 1.

The data input is a valid/ready stream. A beat transfers only on a clock edge where both `in_valid` and `in_ready` are high. The upstream side may hold `in_valid` low for any number of cycles. The block drives `in_ready` high for the whole loading phase and low at all other times, which is how it applies back-pressure between jobs.

`start`, `n_lanes` and the result pins are plain control and status signals. `round_cnt` and `round_tick` expose the folding progress for debug.

Top module: `tree_sum_reducer`

## Requirements
- R1: After reset, `done`, `in_ready` and `round_tick` are 0, and `round_cnt` and `sum_out` are 0.
- R2: `start` is acted on only while the block is idle. It latches the lane count, clears all lanes and `round_cnt`, and raises `in_ready` from the next cycle. A `start` seen during a job has no effect on its result. While idle, `in_ready` is 0 and a presented beat leaves `sum_out` unchanged.
- R3: An `n_lanes` of 0 is treated as 1, and a value above LANES is treated as LANES.
- R4: The block accepts exactly N×SLICE beats. Beat number i (counting from 0) is added to lane floor(i/SLICE). While loading, `in_ready` stays high across upstream stalls.
- R5: Each fold round first notes whether the active count h is odd. If it is, lane 0 adds lane h−1. The count then becomes floor(h/2), and every lane p below the new count adds lane p+floor(h/2). All additions in a round read the lane values from before that round. The final `sum_out` equals the sum of all accepted beats.
- R6: Each round raises `round_tick` for one cycle, in the cycle right after the round's writes. `round_cnt` goes up by one at the same edge. A job ends with `round_cnt` equal to floor(log2 N).
- R7: With N = 1, no fold round runs. `done` rises in the cycle right after the last beat is accepted, and `round_cnt` stays 0.
- R8: `done` is a single-cycle pulse, R+1 cycles after the edge that accepts the last beat, where R is the number of rounds. `sum_out` and `round_cnt` then hold until the next accepted `start`.
- R9: `sum_out` is DW + ceil(log2(LANES×SLICE)) bits wide, so the largest possible input sum appears without wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a job; sampled only while idle |
| n_lanes | input | $clog2(LANES+1) | Number of active lanes, clamped to 1..LANES |
| in_valid | input | 1 | Upstream element is valid |
| in_data | input | DW | Unsigned element value |
| in_ready | output | 1 | Block accepts an element (high only while loading) |
| sum_out | output | DW+$clog2(LANES*SLICE) | Lane 0 value; holds the total after `done` |
| done | output | 1 | One-cycle pulse when the total is ready |
| round_cnt | output | $clog2(floor(log2 LANES)+1) | Number of fold rounds completed in this job |
| round_tick | output | 1 | Pulses once after each fold round commits |

## Verification
The hardest case to reach from the ports is a round where lane 0 takes both the odd leftover and its pairwise partner. That add must use values from before the round, or a lane is dropped or counted twice. The stimulus reaches it with lane counts of 7 and 10, where odd counts appear in rounds that also do pairwise adds. The element values differ from lane to lane, so any wrong pairing changes the total. Separate jobs insert upstream stalls, pulse `start` mid-job, and drive all-maximum values.

// File: rtl/trs_pkg.sv
package trs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_FOLD = 2'd2,
    ST_FIN  = 2'd3
  } trs_state_e;
endpackage

// File: rtl/trs_ingest.sv
module trs_ingest #(
  parameter int LANES = 10,
  parameter int SLICE = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     loading,
  input  logic                     in_valid,
  input  logic [$clog2(LANES)-1:0] last_lane,
  output logic                     accept,
  output logic [$clog2(LANES)-1:0] lane_sel,
  output logic                     last_beat
);
  localparam int LIW = $clog2(LANES);
  localparam int SW  = (SLICE > 1) ? $clog2(SLICE) : 1;

  logic [LIW-1:0] lptr_q;
  logic [SW-1:0]  eidx_q;
  logic           slice_end;

  assign accept    = in_valid && loading;
  assign slice_end = (eidx_q == SW'(SLICE - 1));
  assign last_beat = accept && slice_end && (lptr_q == last_lane);
  assign lane_sel  = lptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lptr_q <= '0;
      eidx_q <= '0;
    end else if (clear) begin
      lptr_q <= '0;
      eidx_q <= '0;
    end else if (accept) begin
      if (slice_end) begin
        eidx_q <= '0;
        lptr_q <= lptr_q + 1'b1;
      end else begin
        eidx_q <= eidx_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/trs_lanes.sv
module trs_lanes #(
  parameter int LANES = 10,
  parameter int DW    = 8,
  parameter int RW    = 14,
  parameter int NW    = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     clear,
  input  logic                     acc_en,
  input  logic [$clog2(LANES)-1:0] acc_sel,
  input  logic [DW-1:0]            acc_data,
  input  logic                     fold_en,
  input  logic [NW-1:0]            half,
  output logic [RW-1:0]            lane0
);
  localparam int LIW = $clog2(LANES);

  logic [RW-1:0] lane_q [LANES];
  logic [NW-1:0] new_half;

  assign new_half = half >> 1;
  assign lane0    = lane_q[0];

  for (genvar p = 0; p < LANES; p++) begin : g_lane
    logic [RW-1:0] q;
    logic [RW-1:0] partner;
    logic [RW-1:0] extra;

    // value from the upper half that this lane folds in (pre-round value)
    always_comb begin
      partner = '0;
      for (int k = 0; k < LANES; k++)
        if (k == p + int'(new_half)) partner = lane_q[k];
    end

    if (p == 0) begin : g_odd
      // lane 0 also absorbs the leftover top lane when the count is odd
      always_comb begin
        extra = '0;
        if (half[0])
          for (int k = 0; k < LANES; k++)
            if (k == int'(half) - 1) extra = lane_q[k];
      end
    end else begin : g_plain
      assign extra = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q <= '0;
      end else if (clear) begin
        q <= '0;
      end else if (acc_en && (acc_sel == LIW'(p))) begin
        q <= q + RW'(acc_data);
      end else if (fold_en && (p < int'(new_half))) begin
        q <= q + partner + extra;
      end
    end

    assign lane_q[p] = q;
  end
endmodule

// File: rtl/trs_ctrl.sv
module trs_ctrl
  import trs_pkg::*;
#(
  parameter int LANES = 10,
  parameter int NW    = 4,
  parameter int CW    = 3
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     start,
  input  logic [NW-1:0]            n_lanes,
  input  logic                     last_beat,
  output logic                     clear,
  output logic                     loading,
  output logic                     fold_en,
  output logic [NW-1:0]            half,
  output logic [$clog2(LANES)-1:0] last_lane,
  output logic                     done,
  output logic [CW-1:0]            round_cnt,
  output logic                     round_tick
);
  localparam int LIW = $clog2(LANES);

  trs_state_e    state_q;
  logic [NW-1:0] half_q;
  logic [NW-1:0] n_eff;
  logic [CW-1:0] rnd_q;
  logic          tick_q;

  always_comb begin
    if (n_lanes == '0)                n_eff = NW'(1);
    else if (n_lanes > NW'(LANES))    n_eff = NW'(LANES);
    else                              n_eff = n_lanes;
  end

  assign clear      = (state_q == ST_IDLE) && start;
  assign loading    = (state_q == ST_LOAD);
  assign fold_en    = (state_q == ST_FOLD);
  assign done       = (state_q == ST_FIN);
  assign half       = half_q;
  assign last_lane  = LIW'(half_q - 1'b1);
  assign round_cnt  = rnd_q;
  assign round_tick = tick_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      half_q  <= NW'(1);
      rnd_q   <= '0;
      tick_q  <= 1'b0;
    end else begin
      tick_q <= (state_q == ST_FOLD);
      case (state_q)
        ST_IDLE: if (start) begin
          state_q <= ST_LOAD;
          half_q  <= n_eff;
          rnd_q   <= '0;
        end
        ST_LOAD: if (last_beat) begin
          state_q <= (half_q == NW'(1)) ? ST_FIN : ST_FOLD;
        end
        ST_FOLD: begin
          half_q <= half_q >> 1;
          rnd_q  <= rnd_q + 1'b1;
          if ((half_q >> 1) == NW'(1)) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/tree_sum_reducer.sv
module tree_sum_reducer #(
  parameter int LANES = 10,
  parameter int SLICE = 4,
  parameter int DW    = 8,
  localparam int NW         = $clog2(LANES + 1),
  localparam int LIW        = $clog2(LANES),
  localparam int RW         = DW + $clog2(LANES * SLICE),
  localparam int ROUNDS_MAX = $clog2(LANES + 1) - 1,
  localparam int CW         = $clog2(ROUNDS_MAX + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [NW-1:0] n_lanes,
  input  logic          in_valid,
  input  logic [DW-1:0] in_data,
  output logic          in_ready,
  output logic [RW-1:0] sum_out,
  output logic          done,
  output logic [CW-1:0] round_cnt,
  output logic          round_tick
);
  logic           clear, loading, fold_en, accept, last_beat;
  logic [NW-1:0]  half;
  logic [LIW-1:0] last_lane, lane_sel;

  assign in_ready = loading;

  trs_ctrl #(.LANES(LANES), .NW(NW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .n_lanes(n_lanes),
    .last_beat(last_beat), .clear(clear), .loading(loading),
    .fold_en(fold_en), .half(half), .last_lane(last_lane), .done(done),
    .round_cnt(round_cnt), .round_tick(round_tick)
  );

  trs_ingest #(.LANES(LANES), .SLICE(SLICE)) u_ingest (
    .clk(clk), .rst_n(rst_n), .clear(clear), .loading(loading),
    .in_valid(in_valid), .last_lane(last_lane), .accept(accept),
    .lane_sel(lane_sel), .last_beat(last_beat)
  );

  trs_lanes #(.LANES(LANES), .DW(DW), .RW(RW), .NW(NW)) u_lanes (
    .clk(clk), .rst_n(rst_n), .clear(clear), .acc_en(accept),
    .acc_sel(lane_sel), .acc_data(in_data), .fold_en(fold_en),
    .half(half), .lane0(sum_out)
  );
endmodule

// File: rtl/trs_checker.sv
module trs_checker #(
  parameter int RW         = 14,
  parameter int CW         = 3,
  parameter int ROUNDS_MAX = 3
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          done,
  input logic          round_tick,
  input logic [CW-1:0] round_cnt,
  input logic [RW-1:0] sum_out
);
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_hold_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> ($stable(sum_out) && $stable(round_cnt)));

  p_ready_on_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && !in_valid) |=> in_ready);

  p_no_ready_at_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);

  p_round_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    round_tick |-> (round_cnt == CW'($past(round_cnt) + 1'b1)));

  p_round_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
    int'(round_cnt) <= ROUNDS_MAX);
endmodule

bind tree_sum_reducer trs_checker #(.RW(RW), .CW(CW), .ROUNDS_MAX(ROUNDS_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .done(done), .round_tick(round_tick), .round_cnt(round_cnt), .sum_out(sum_out)
);

// File: tb/tb_tree_sum_reducer.sv
`timescale 1ns/1ps
module tb_tree_sum_reducer;
  localparam int LANES = 10;
  localparam int SLICE = 4;
  localparam int DW    = 8;
  localparam int NW    = $clog2(LANES + 1);
  localparam int RW    = DW + $clog2(LANES * SLICE);
  localparam int CW    = $clog2($clog2(LANES + 1));

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [NW-1:0] n_lanes = '0;
  logic          in_valid = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic          in_ready, done, round_tick;
  logic [RW-1:0] sum_out;
  logic [CW-1:0] round_cnt;

  int n_checks = 0;
  int n_fail   = 0;

  always #2.5 clk = ~clk;

  tree_sum_reducer #(.LANES(LANES), .SLICE(SLICE), .DW(DW)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .n_lanes(n_lanes),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .sum_out(sum_out), .done(done), .round_cnt(round_cnt), .round_tick(round_tick)
  );

  task automatic chk(input string req, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int elem(input int i, input int seed);
    if (seed < 0) return 255;
    return (i * 37 + seed * 53 + 11) % 256;
  endfunction

  // one job: returns after done and the hold/idle checks
  task automatic run_job(input string req, input int n_req, input int seed,
                         input bit stall, input bit poke);
    int neff, total, rounds, h, lat, ticks;
    logic [RW-1:0] held;
    neff = (n_req == 0) ? 1 : ((n_req > LANES) ? LANES : n_req);
    total = 0;
    for (int i = 0; i < neff * SLICE; i++) total += elem(i, seed);
    rounds = 0; h = neff;
    while (h > 1) begin h = h / 2; rounds++; end

    @(negedge clk);
    start = 1'b1; n_lanes = NW'(n_req);
    @(negedge clk);
    start = 1'b0;
    chk("R2", "in_ready after start", in_ready, 1);
    chk("R2", "round_cnt cleared", round_cnt, 0);

    for (int i = 0; i < neff * SLICE; i++) begin
      if (stall && (i % 3 == 1)) begin
        in_valid = 1'b0;
        if (poke && i == 4) start = 1'b1;  // R2: ignored mid-job
        @(negedge clk);
        start = 1'b0;
        chk("R4", "in_ready held across stall", in_ready, 1);
      end
      in_valid = 1'b1;
      in_data  = DW'(elem(i, seed));
      @(negedge clk);
    end
    in_valid = 1'b0;

    lat = 1; ticks = round_tick;
    while (!done && lat < 40) begin
      @(negedge clk);
      lat++;
      ticks += round_tick;
    end
    chk(req, "sum_out", sum_out, total);
    chk("R8", "done latency", lat, rounds + 1);
    chk("R6", "round_cnt", round_cnt, rounds);
    chk("R6", "round_tick pulses", ticks, rounds);
    chk("R2", "in_ready low at done", in_ready, 0);
    held = sum_out;

    in_valid = 1'b1; in_data = 8'hA5;   // beat offered while idle
    @(negedge clk);
    chk("R8", "done single cycle", done, 0);
    chk("R8", "sum_out held", sum_out, held);
    @(negedge clk);
    chk("R2", "in_ready low when idle", in_ready, 0);
    chk("R2", "idle beat ignored", sum_out, held);
    chk("R8", "round_cnt held", round_cnt, rounds);
    in_valid = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1", "done", done, 0);
    chk("R1", "in_ready", in_ready, 0);
    chk("R1", "round_tick", round_tick, 0);
    chk("R1", "round_cnt", round_cnt, 0);
    chk("R1", "sum_out", sum_out, 0);
  endtask

  task automatic t_ten_lanes();  run_job("R5", 10, 1, 1'b0, 1'b0); endtask
  task automatic t_odd_twice();  run_job("R5", 7, 2, 1'b0, 1'b0); endtask
  task automatic t_pow2();       run_job("R5", 8, 3, 1'b0, 1'b0); endtask
  task automatic t_three();      run_job("R5", 3, 4, 1'b0, 1'b0); endtask
  task automatic t_single();     run_job("R7", 1, 5, 1'b0, 1'b0); endtask
  task automatic t_clamp_low();  run_job("R3", 0, 6, 1'b0, 1'b0); endtask
  task automatic t_clamp_high(); run_job("R3", 15, 7, 1'b0, 1'b0); endtask
  task automatic t_stall_poke(); run_job("R4", 6, 8, 1'b1, 1'b1); endtask
  task automatic t_max_values(); run_job("R9", 10, -1, 1'b0, 1'b0); endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_ten_lanes();
    t_odd_twice();
    t_pow2();
    t_three();
    t_single();
    t_clamp_low();
    t_clamp_high();
    t_stall_poke();
    t_max_values();
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule